// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

The block holds two 16-bit timer/counter units. Each unit is made of a high byte and a low byte. A unit advances on one of two sources: an internal tick that the block makes by dividing the clock by `TICK_DIV`, or a falling edge on its own external count pin. Before it is used, the count pin passes through a synchronizer. A run bit allows counting. When the unit's gate bit is set, counting also needs the unit's external gate pin to be high. Each unit works in one of four modes: a prescaled 13-bit count, a full 16-bit count, an 8-bit count that reloads itself, and a split mode. In split mode, unit 0 becomes two independent 8-bit timers and unit 1 stops.

On rollover, a unit sets an overflow flag. The flag stays set until an acknowledge input clears it or a write to the control register replaces it. Unit 1 also gives out a one-cycle rollover pulse, which a serial baud-rate generator can use. Software reads and writes the control register, the mode register and the four count bytes through a plain register port.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 00h, both overflow flags are 0 and the rollover pulse is 0.
- R2: The register map is: address 0 control, 1 mode, 2 unit-0 low byte, 3 unit-0 high byte, 4 unit-1 low byte, 5 unit-1 high byte. Addresses 6 and 7 read 00h and ignore writes. In the control register, bit 2i is the run bit of unit i and bit 2i+1 is its overflow flag. Bits 7:4 read 0.
- R3: The mode register has one nibble per unit: unit 1 in bits 7:4 and unit 0 in bits 3:0. Within a nibble, bit 3 is gate, bit 2 selects the external source and bits 1:0 are the mode. In mode 0, bits 4:0 of the low byte form a divide-by-32 prescaler whose carry increments the high byte. Low-byte bits 7:5 stay unchanged. The unit overflows when the high byte wraps from FFh.
- R4: In mode 1, the two bytes count as one 16-bit value and overflow when they wrap from FFFFh to 0000h.
- R5: In mode 2, the low byte counts. When it rolls over from FFh, it loads the high byte's value and the unit overflows.
- R6: In mode 3, unit 0's low byte is an 8-bit counter under unit 0's run, gate and source controls, and it sets flag 0. Unit 0's high byte counts internal ticks while unit 1's run bit is 1, and it sets flag 1.
- R7: In mode 3, unit 1 holds its count and sets no flag.
- R8: With gate 0, a unit counts while its run bit is 1. With gate 1, it also needs its synchronized gate pin to be high.
- R9: With source select 0, the unit counts one internal tick every `TICK_DIV` clocks. With source select 1, it counts once for each falling edge of its count pin, seen after `SYNC_STAGES` synchronizer flops.
- R10: A flag is set on its overflow and cleared by `ack_clr[i]`. A flag set and a clear in the same cycle leave it set. A control write overrides both.
- R11: `t1_ovf_pulse` goes high for one cycle, one clock after unit 1 rolls over. This happens in every unit-0 mode, including split mode, in which flag 1 comes from unit 0's high byte.
- R12: A register write to a count byte takes priority over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pin | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | External gate pins, one per unit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| ack_clr | input | 2 | Clears the overflow flag of unit i |
| ovf_flag | output | 2 | Overflow flags |
| t1_ovf_pulse | output | 1 | One-cycle unit-1 rollover pulse |

## Verification
The bench goes after these corner cases and the faults each one exposes:
- **Mode 0 prescaler wrap.** A design that let the carry reach low-byte bits 7:5 would corrupt those bits.
- **Mode 2 reload.** A design that simply wrapped the low byte to 00h would read below the reload value.
- **Split mode.** If the high byte's overflow were not routed to flag 1, that flag would stay clear. If unit 1's own rollover were allowed onto flag 1, it would be set when it should not be.
- **External edge landing with a low-byte write.** A wrong priority there leaves the count one past the written value.
- **Closed gate.** The count must stay frozen while the gate is closed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int DW      = 8;
   localparam int NUM_TMR = 2;
   localparam int REG_AW  = 3;

   localparam logic [REG_AW-1:0] ADDR_CTRL     = 3'd0;
   localparam logic [REG_AW-1:0] ADDR_MODE     = 3'd1;
   localparam int                ADDR_CNT_BASE = 2;

   typedef enum logic [1:0] {
      TM_PRESC13 = 2'd0,
      TM_WIDE16  = 2'd1,
      TM_RELOAD8 = 2'd2,
      TM_SPLIT   = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic      gate;
      logic      ext_sel;
      tmr_mode_e mode;
   } tmr_cfg_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] div_cnt;

   assign tick = (div_cnt == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_cnt <= '0;
      else if (tick) div_cnt <= '0;
      else           div_cnt <= div_cnt + CW'(1);
   end

   // R9
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic lvl,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], pin};
         prev  <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign fall = prev & ~chain[STAGES-1];

   // R9
   edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter bit SPLIT_OK = 1'b1,
   parameter int PRESC_W  = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  tmr_mode_e     mode,
   input  logic          lo_inc,
   input  logic          hi_inc,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] lo_q,
   output logic [DW-1:0] hi_q,
   output logic          ovf,
   output logic          hi_ovf
);
   logic [DW-1:0]    lo_n, hi_n;
   logic [DW-1:0]    sp_lo_n, sp_hi_n;
   logic             sp_ovf, sp_hovf;
   logic [PRESC_W:0] pre_sum;
   logic [2*DW:0]    wide_sum;

   generate
      if (SPLIT_OK) begin : g_split
         always_comb begin
            if (lo_inc) {sp_ovf, sp_lo_n} = {1'b0, lo_q} + (DW+1)'(1);
            else        {sp_ovf, sp_lo_n} = {1'b0, lo_q};
            if (hi_inc) {sp_hovf, sp_hi_n} = {1'b0, hi_q} + (DW+1)'(1);
            else        {sp_hovf, sp_hi_n} = {1'b0, hi_q};
         end
      end else begin : g_hold
         logic unused_hi_inc;
         assign unused_hi_inc = hi_inc;
         assign sp_lo_n = lo_q;
         assign sp_hi_n = hi_q;
         assign sp_ovf  = 1'b0;
         assign sp_hovf = 1'b0;

         // R7
         split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == TM_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
      end
   endgenerate

   always_comb begin
      lo_n     = lo_q;
      hi_n     = hi_q;
      ovf      = 1'b0;
      hi_ovf   = 1'b0;
      pre_sum  = {1'b0, lo_q[PRESC_W-1:0]} + (PRESC_W+1)'(1);
      wide_sum = {1'b0, hi_q, lo_q} + (2*DW+1)'(1);
      unique case (mode)
         TM_PRESC13: if (lo_inc) begin
            lo_n[PRESC_W-1:0] = pre_sum[PRESC_W-1:0];
            if (pre_sum[PRESC_W]) {ovf, hi_n} = {1'b0, hi_q} + (DW+1)'(1);
         end
         TM_WIDE16: if (lo_inc) {ovf, hi_n, lo_n} = wide_sum;
         TM_RELOAD8: if (lo_inc) begin
            if (&lo_q) begin
               lo_n = hi_q;
               ovf  = 1'b1;
            end else begin
               lo_n = lo_q + DW'(1);
            end
         end
         TM_SPLIT: begin
            lo_n   = sp_lo_n;
            hi_n   = sp_hi_n;
            ovf    = sp_ovf;
            hi_ovf = sp_hovf;
         end
      endcase
      if (wr_lo) lo_n = wdata;
      if (wr_hi) hi_n = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_RELOAD8 && lo_inc && (&lo_q) && !wr_lo && !wr_hi) |=> (lo_q == $past(hi_q)));

   // R3
   presc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_PRESC13 && !wr_lo) |=> (lo_q[DW-1:PRESC_W] == $past(lo_q[DW-1:PRESC_W])));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int TICK_DIV    = 12,
   parameter int SYNC_STAGES = 2,
   parameter int PRESC_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cnt_pin,
   input  logic [1:0]        gate_pin,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic [1:0]        ack_clr,
   output logic [1:0]        ovf_flag,
   output logic              t1_ovf_pulse
);
   localparam int CFG_W = $bits(tmr_cfg_t);

   if (TICK_DIV < 2)                  begin : g_bad_div  $error("TICK_DIV must be at least 2"); end
   if (SYNC_STAGES < 2)               begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
   if (PRESC_W < 1 || PRESC_W >= DW)  begin : g_bad_pre  $error("PRESC_W must lie in 1..DW-1"); end

   logic                 tick;
   logic [DW-1:0]        mode_q;
   logic [NUM_TMR-1:0]   run_q, flag_q, set_ovf;
   logic [NUM_TMR-1:0]   cnt_fall, gate_lvl, cnt_lvl;
   logic [NUM_TMR-1:0]   lo_inc, wr_lo, wr_hi, u_ovf, u_hovf;
   logic [DW-1:0]        lo_q [NUM_TMR];
   logic [DW-1:0]        hi_q [NUM_TMR];
   tmr_cfg_t             cfg  [NUM_TMR];
   logic                 ctrl_wr, t0_split, pulse_q;
   logic                 unused_sig;

   assign ctrl_wr    = reg_we && (reg_addr == ADDR_CTRL);
   assign t0_split   = (cfg[0].mode == TM_SPLIT);
   assign unused_sig = u_hovf[1] ^ (^cnt_lvl) ^ (^gate_lvl[1]);

   tmr_tick_gen #(.DIV(TICK_DIV)) tick_i (.clk(clk), .rst_n(rst_n), .tick(tick));

   genvar i;
   generate
      for (i = 0; i < NUM_TMR; i++) begin : g_tmr
         tmr_pin_sync #(.STAGES(SYNC_STAGES)) cnt_sync_i (
            .clk(clk), .rst_n(rst_n), .pin(cnt_pin[i]), .lvl(cnt_lvl[i]), .fall(cnt_fall[i]));
         logic unused_gate_fall;
         tmr_pin_sync #(.STAGES(SYNC_STAGES)) gate_sync_i (
            .clk(clk), .rst_n(rst_n), .pin(gate_pin[i]), .lvl(gate_lvl[i]), .fall(unused_gate_fall));

         assign cfg[i]  = tmr_cfg_t'(mode_q[CFG_W*i +: CFG_W]);
         assign wr_lo[i] = reg_we && (reg_addr == REG_AW'(ADDR_CNT_BASE + 2*i));
         assign wr_hi[i] = reg_we && (reg_addr == REG_AW'(ADDR_CNT_BASE + 2*i + 1));
         assign lo_inc[i] = run_q[i] && (!cfg[i].gate || gate_lvl[i]) &&
                            (cfg[i].ext_sel ? cnt_fall[i] : tick);

         tmr_unit #(.SPLIT_OK(i == 0), .PRESC_W(PRESC_W)) unit_i (
            .clk(clk), .rst_n(rst_n), .mode(cfg[i].mode),
            .lo_inc(lo_inc[i]),
            .hi_inc((i == 0) ? (run_q[NUM_TMR-1] & tick) : 1'b0),
            .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(reg_wdata),
            .lo_q(lo_q[i]), .hi_q(hi_q[i]), .ovf(u_ovf[i]), .hi_ovf(u_hovf[i]));

         if (i == NUM_TMR-1) begin : g_last
            assign set_ovf[i] = t0_split ? u_hovf[0] : u_ovf[i];
         end else begin : g_own
            assign set_ovf[i] = u_ovf[i];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q[i]  <= 1'b0;
               flag_q[i] <= 1'b0;
            end else if (ctrl_wr) begin
               run_q[i]  <= reg_wdata[2*i];
               flag_q[i] <= reg_wdata[2*i+1];
            end else if (set_ovf[i]) begin
               flag_q[i] <= 1'b1;
            end else if (ack_clr[i]) begin
               flag_q[i] <= 1'b0;
            end
         end

         // R10
         flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_ovf[i] && !ctrl_wr) |=> flag_q[i]);
         // R10
         ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_clr[i] && !set_ovf[i] && !ctrl_wr) |=> !flag_q[i]);
         // R8
         gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[i].gate && !gate_lvl[i] && cfg[i].mode != TM_SPLIT && !wr_lo[i] && !wr_hi[i])
            |=> ($stable(lo_q[i]) && $stable(hi_q[i])));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         pulse_q <= 1'b0;
      end else begin
         if (reg_we && reg_addr == ADDR_MODE) mode_q <= reg_wdata;
         pulse_q <= u_ovf[NUM_TMR-1];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_CTRL) begin
         for (int k = 0; k < NUM_TMR; k++) begin
            reg_rdata[2*k]   = run_q[k];
            reg_rdata[2*k+1] = flag_q[k];
         end
      end else if (reg_addr == ADDR_MODE) begin
         reg_rdata = mode_q;
      end else begin
         for (int k = 0; k < NUM_TMR; k++) begin
            if (reg_addr == REG_AW'(ADDR_CNT_BASE + 2*k))     reg_rdata = lo_q[k];
            if (reg_addr == REG_AW'(ADDR_CNT_BASE + 2*k + 1)) reg_rdata = hi_q[k];
         end
      end
   end

   assign ovf_flag     = flag_q;
   assign t1_ovf_pulse = pulse_q;

   // R11
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t1_ovf_pulse |=> !t1_ovf_pulse);
endmodule

// File: tb/tmr_pair_tb_top.sv
`timescale 1ns/100ps
module tmr_pair_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 12;
   localparam int SYNC       = 2;
   localparam int PRE        = 32;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [1:0] cnt_pin = 2'b11, gate_pin = 2'b11, ack_clr = 2'b00;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic [1:0] ovf_flag;
   logic       t1_ovf_pulse;

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_pair dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ack_clr(ack_clr), .ovf_flag(ovf_flag), .t1_ovf_pulse(t1_ovf_pulse));

   // ---------------- behavioural reference model ----------------
   int m_div;
   int m_cs [2][SYNC];
   int m_gs [2][SYNC];
   int m_cp [2];
   int m_lo [2], m_hi [2], m_run [2], m_flag [2];
   int m_mode, m_pulse;

   function automatic int mread(int a);
      case (a)
         0: return m_run[0] + 2*m_flag[0] + 4*m_run[1] + 8*m_flag[1];
         1: return m_mode;
         2: return m_lo[0];
         3: return m_hi[0];
         4: return m_lo[1];
         5: return m_hi[1];
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin : mdl
      int tick, hov, v, md, fall, glvl, g, sel, wctrl;
      int inc [2];
      int ov  [2];
      int nlo [2];
      int nhi [2];
      if (!rst_n) begin
         m_div = 0; m_mode = 0; m_pulse = 0;
         for (int i = 0; i < 2; i++) begin
            m_lo[i] = 0; m_hi[i] = 0; m_run[i] = 0; m_flag[i] = 0; m_cp[i] = 0;
            for (int k = 0; k < SYNC; k++) begin m_cs[i][k] = 0; m_gs[i][k] = 0; end
         end
      end else begin
         tick = (m_div == TICK_DIV-1);
         for (int i = 0; i < 2; i++) begin
            fall = m_cp[i] && !m_cs[i][SYNC-1];
            glvl = m_gs[i][SYNC-1];
            g    = (m_mode >> (4*i+3)) & 1;
            sel  = (m_mode >> (4*i+2)) & 1;
            inc[i] = m_run[i] && (!g || glvl) && (sel ? fall : tick);
         end
         for (int i = 0; i < 2; i++) begin
            nlo[i] = m_lo[i]; nhi[i] = m_hi[i]; ov[i] = 0;
            md = (m_mode >> (4*i)) & 3;
            if (inc[i]) begin
               case (md)
                  0: begin
                     v = m_hi[i]*PRE + (m_lo[i] % PRE) + 1;
                     if (v == 256*PRE) begin ov[i] = 1; v = 0; end
                     nlo[i] = m_lo[i] - (m_lo[i] % PRE) + (v % PRE);
                     nhi[i] = v / PRE;
                  end
                  1: begin
                     v = m_hi[i]*256 + m_lo[i] + 1;
                     if (v == 65536) begin ov[i] = 1; v = 0; end
                     nhi[i] = v / 256; nlo[i] = v % 256;
                  end
                  2: begin
                     if (m_lo[i] == 255) begin nlo[i] = m_hi[i]; ov[i] = 1; end
                     else nlo[i] = m_lo[i] + 1;
                  end
                  default: begin
                     if (i == 0) begin ov[i] = (m_lo[i] == 255); nlo[i] = (m_lo[i] + 1) % 256; end
                  end
               endcase
            end
         end
         hov = 0;
         if ((m_mode & 3) == 3 && m_run[1] && tick) begin
            hov = (m_hi[0] == 255); nhi[0] = (m_hi[0] + 1) % 256;
         end
         wctrl = reg_we && reg_addr == 0;
         if (reg_we) begin
            case (reg_addr)
               3'd0: begin
                  m_run[0] = reg_wdata[0]; m_flag[0] = reg_wdata[1];
                  m_run[1] = reg_wdata[2]; m_flag[1] = reg_wdata[3];
               end
               3'd1: m_mode = reg_wdata;
               3'd2: nlo[0] = reg_wdata;
               3'd3: nhi[0] = reg_wdata;
               3'd4: nlo[1] = reg_wdata;
               3'd5: nhi[1] = reg_wdata;
               default: ;
            endcase
         end
         if (!wctrl) begin
            for (int i = 0; i < 2; i++) begin
               v = (i == 0) ? ov[0] : (((m_mode & 3) == 3) ? hov : ov[1]);
               if (v) m_flag[i] = 1;
               else if (ack_clr[i]) m_flag[i] = 0;
            end
         end
         m_pulse = ov[1];
         for (int i = 0; i < 2; i++) begin
            m_lo[i] = nlo[i]; m_hi[i] = nhi[i];
            m_cp[i] = m_cs[i][SYNC-1];
            for (int k = SYNC-1; k > 0; k--) begin
               m_cs[i][k] = m_cs[i][k-1]; m_gs[i][k] = m_gs[i][k-1];
            end
            m_cs[i][0] = cnt_pin[i]; m_gs[i][0] = gate_pin[i];
         end
         m_div = tick ? 0 : m_div + 1;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n && !finished) begin
         chk({cur_req, " flags"}, int'(ovf_flag), 2*m_flag[1] + m_flag[0]);
         chk({cur_req, " pulse"}, int'(t1_ovf_pulse), m_pulse);
         chk({cur_req, " rdata"}, int'(reg_rdata), mread(int'(reg_addr)));
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(int a, output int v);
      reg_addr = 3'(a);
      #0.5;
      v = int'(reg_rdata);
   endtask

   task automatic snap(string req);
      int v;
      for (int a = 0; a < 6; a++) begin
         rd(a, v);
         chk(req, v, mread(a));
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int v, pulses, prevp;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 8; a++) begin rd(a, v); chk("R1 reset reg", v, 0); end
      chk("R1 flags", int'(ovf_flag), 0);
      chk("R1 pulse", int'(t1_ovf_pulse), 0);

      // R2 register map
      cur_req = "R2";
      wr(2, 'h5A); rd(2, v); chk("R2 lo0", v, 'h5A);
      wr(5, 'hC3); rd(5, v); chk("R2 hi1", v, 'hC3);
      wr(6, 'hFF); rd(6, v); chk("R2 unmapped", v, 0);
      wr(0, 'hF0); rd(0, v); chk("R2 ctrl upper", v, 0);

      // R10 control write sets flags, ack clears
      cur_req = "R10";
      wr(0, 'h0A); chk("R10 write sets", int'(ovf_flag), 3);
      ack_clr = 2'b01; @(negedge clk); ack_clr = 2'b00;
      chk("R10 ack clear", int'(ovf_flag), 2);
      wr(0, 0); chk("R10 write clears", int'(ovf_flag), 0);

      // R4 16-bit mode
      cur_req = "R4";
      wr(2, 'hF0); wr(3, 'hFF); wr(1, 'h01); wr(0, 'h01);
      idle(16*TICK_DIV + 30);
      chk("R4 overflow flag", int'(ovf_flag[0]), 1);
      snap("R4");
      wr(0, 0);

      // R3 13-bit prescaled mode
      cur_req = "R3";
      wr(1, 'h00); wr(3, 'hFF); wr(2, 'hFC); wr(0, 'h01);
      idle(5*TICK_DIV);
      chk("R3 overflow flag", int'(ovf_flag[0]), 1);
      rd(2, v); chk("R3 lo upper bits kept", v >> 5, 7);
      rd(3, v); chk("R3 hi wrapped", v, 0);
      wr(0, 0);

      // R5 auto-reload
      cur_req = "R5";
      wr(1, 'h02); wr(3, 'hF0); wr(2, 'hFE); wr(0, 'h01);
      idle(100);
      rd(2, v); chk("R5 lo not below reload", int'(v >= 'hF0), 1);
      chk("R5 flag", int'(ovf_flag[0]), 1);
      snap("R5");
      wr(0, 0);

      // R8 gating
      cur_req = "R8";
      gate_pin[0] = 1'b0;
      wr(1, 'h09); wr(2, 'h10); wr(3, 0); wr(0, 'h01);
      idle(100);
      rd(2, v); chk("R8 gate closed holds", v, 'h10);
      gate_pin[0] = 1'b1;
      idle(100);
      rd(2, v); chk("R8 gate open counts", int'(v != 'h10), 1);
      snap("R8");
      wr(0, 0);

      // R9 external edges
      cur_req = "R9";
      wr(1, 'h05); wr(2, 0); wr(3, 0); wr(0, 'h01);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk) cnt_pin[0] = 1'b0; idle(4);
         cnt_pin[0] = 1'b1; idle(4);
      end
      idle(6);
      rd(2, v); chk("R9 five falling edges", v, 5);

      // R12 write beats a count in the same cycle
      cur_req = "R12";
      @(negedge clk) cnt_pin[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h77;
      @(negedge clk) reg_we = 1'b0;
      rd(2, v); chk("R12 write wins", v, 'h77);
      cnt_pin[0] = 1'b1; idle(4);
      wr(0, 0);

      // R6 split mode
      cur_req = "R6";
      wr(1, 'h03); wr(2, 'hFE); wr(3, 'hFE); wr(4, 0); wr(5, 0); wr(0, 'h05);
      idle(40);
      chk("R6 low byte flag0", int'(ovf_flag[0]), 1);
      chk("R6 high byte flag1", int'(ovf_flag[1]), 1);
      rd(5, v); chk("R6 unit1 no wrap", v, 0);
      snap("R6");
      wr(0, 0);

      // R7 unit 1 halts in mode 3
      cur_req = "R7";
      wr(1, 'h30); wr(4, 'h34); wr(5, 'h12); wr(0, 'h04);
      idle(100);
      rd(4, v); chk("R7 lo1 held", v, 'h34);
      rd(5, v); chk("R7 hi1 held", v, 'h12);
      chk("R7 no flag1", int'(ovf_flag[1]), 0);
      wr(0, 0);

      // R11 rollover pulse while unit 0 is split
      cur_req = "R11";
      wr(1, 'h23); wr(4, 'hFD); wr(5, 'hFD); wr(2, 0); wr(3, 0); wr(0, 'h04);
      pulses = 0; prevp = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (t1_ovf_pulse) pulses++;
         if (t1_ovf_pulse && prevp) chk("R11 pulse one cycle", 1, 0);
         prevp = int'(t1_ovf_pulse);
      end
      chk("R11 pulses seen", int'(pulses >= 4), 1);
      chk("R11 flag1 from split high byte only", int'(ovf_flag[1]), 0);
      wr(0, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule